// File: doc/BRIEF.md
# Six-Input Column Counter Row

This block reduces a row of partial-product columns, each six bits high, to one sum bit and one carry bit per column. Every column holds a (6,2) counter slice. The slice adds its six data bits of equal weight and three side carries that come from the column of next lower weight. It returns a sum bit of the column's own weight and a carry bit of the next weight. It also sends three side carries to the column of next higher weight.

The side carries are arranged so that no carry ripples along the row. The first two side carries of a column come only from its own data bits. The third one depends only on those bits and on the first side carry that arrives from below. The logic depth of the row therefore stays the same for any width. A level of a multiplier's reduction tree uses one such row. The side carries into the lowest column and out of the highest column appear on ports, so a boundary can tie them to zero or chain them onward.

Top module: `csa6_row`

## Requirements
- R1: For every column, the count of its six data bits plus its three incoming side carries equals sum + 2*carry + 2*(count of its three outgoing side carries).
- R2: Each column's sum bit is the XOR of its six data bits and its three incoming side carries.
- R3: Outgoing side carry 0 is 1 exactly when at least two of data bits 0..2 of the column are 1. Outgoing side carry 1 is 1 exactly when at least two of data bits 3..5 are 1. Neither depends on any incoming side carry.
- R4: Outgoing side carry 2 does not change when incoming side carries 1 and 2 change.
- R5: Across the row, sum over columns j of 2^j*(data bit count) plus the count of carry_in equals sum over j of 2^j*(sum_o[j] + 2*carry_o[j]) plus 2^N*(count of carry_out).
- R6: All-zero data and carry_in give all-zero sum_o, carry_o and carry_out.
- R7: Side carry k leaving column j is side carry k entering column j+1. carry_in feeds column 0 and carry_out leaves column N-1. With every data bit 1 and carry_in zero, carry_out is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| col_bits | input | N x 6 | Six data bits for each column, column 0 of least weight |
| carry_in | input | 3 | Side carries into column 0 |
| sum_o | output | N | Sum bit of each column, same weight as the column |
| carry_o | output | N | Carry bit of each column, weight of the next column |
| carry_out | output | 3 | Side carries leaving column N-1 |

## Verification
The row is purely combinational, so every output is due in the same cycle as the input pattern that produces it, with no register in between. The bench drives a new pattern just after a rising clock edge. It compares sum_o, carry_o and carry_out with its behavioural model at the next falling edge, once the logic has settled. A single-column instance is swept through all 512 input patterns. The full-width instance checks the weighted-total identity on random and corner patterns.

// File: rtl/csa6_row.sv
module csa6_row #(
  parameter int N = 16
) (
  input  logic [N-1:0][5:0] col_bits,
  input  logic [2:0]        carry_in,
  output logic [N-1:0]      sum_o,
  output logic [N-1:0]      carry_o,
  output logic [2:0]        carry_out
);
  localparam int TW = N + 5;

  logic [N:0][2:0] link;

  assign link[0]   = carry_in;
  assign carry_out = link[N];

  for (genvar j = 0; j < N; j++) begin : g_col
    logic [5:0] b;
    logic [2:0] ci;
    logic [2:0] co;
    logic       sa, sb, sc;

    assign b  = col_bits[j];
    assign ci = link[j];

    assign sa    = b[0] ^ b[1] ^ b[2];
    assign co[0] = (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
    assign sb    = b[3] ^ b[4] ^ b[5];
    assign co[1] = (b[3] & b[4]) | (b[3] & b[5]) | (b[4] & b[5]);
    assign sc    = sa ^ sb ^ ci[0];
    assign co[2] = (sa & sb) | (sa & ci[0]) | (sb & ci[0]);

    assign sum_o[j]   = sc ^ ci[1] ^ ci[2];
    assign carry_o[j] = (sc & ci[1]) | (sc & ci[2]) | (ci[1] & ci[2]);
    assign link[j+1]  = co;

    always_comb begin
      a_r1_col_weight: assert ($countones(b) + $countones(ci) ==
                               int'(sum_o[j]) + 2 * int'(carry_o[j]) + 2 * $countones(link[j+1]))
        else $error("column %0d weight mismatch", j);
      a_r2_sum_parity: assert (sum_o[j] == ^{b, ci})
        else $error("column %0d sum parity mismatch", j);
      a_r3_pair_bound: assert (2 * $countones(link[j+1][1:0]) <= $countones(b))
        else $error("column %0d early carries exceed data", j);
    end
  end

  logic [TW-1:0] w_in, w_out;

  always_comb begin
    w_in  = TW'($countones(carry_in));
    w_out = TW'($countones(carry_out)) << N;
    for (int j = 0; j < N; j++) begin
      w_in  = w_in + (TW'($countones(col_bits[j])) << j);
      w_out = w_out + ((TW'(sum_o[j]) + (TW'(carry_o[j]) << 1)) << j);
    end
    a_r5_row_total: assert (w_in == w_out)
      else $error("row weighted total mismatch");
  end
endmodule

// File: tb/sim_csa6_row.sv
module sim_csa6_row;
  localparam int N = 16;

  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic [N-1:0][5:0] bits0;
  logic [2:0]        cin0;
  logic [N-1:0]      s0, c0;
  logic [2:0]        cout0;

  logic [0:0][5:0]   bits1;
  logic [2:0]        cin1;
  logic [0:0]        s1, c1;
  logic [2:0]        cout1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  csa6_row #(.N(N)) u0 (.col_bits(bits0), .carry_in(cin0), .sum_o(s0), .carry_o(c0), .carry_out(cout0));
  csa6_row #(.N(1)) u1 (.col_bits(bits1), .carry_in(cin1), .sum_o(s1), .carry_o(c1), .carry_out(cout1));

  function automatic int ones(input logic [8:0] v);
    int n = 0;
    for (int i = 0; i < 9; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic row_check(input string req);
    longint lhs = 0, rhs = 0;
    lhs = ones({6'd0, cin0});
    rhs = longint'(ones({6'd0, cout0})) << N;
    for (int j = 0; j < N; j++) begin
      lhs += longint'(ones({3'd0, bits0[j]})) << j;
      rhs += (longint'(s0[j]) + 2 * longint'(c0[j])) << j;
    end
    check(req, rhs, lhs);
  endtask

  logic k3_ref [0:1][0:63];

  initial begin
    bits0 = '0; cin0 = '0; bits1 = '0; cin1 = '0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R6: idle state
    check("R6 sum_o", longint'(s0), 0);
    check("R6 carry_o", longint'(c0), 0);
    check("R6 carry_out", longint'(cout0), 0);
    check("R6 single", longint'({s1, c1, cout1}), 0);

    for (int v = 0; v < 512; v++) begin
      @(posedge clk); #1;
      bits1[0] = v[5:0];
      cin1 = v[8:6];
      @(negedge clk);
      check("R1 slice weight", ones({bits1[0], cin1}),
            int'(s1[0]) + 2 * int'(c1[0]) + 2 * ones({6'd0, cout1}));
      check("R2 parity", longint'(s1[0]), longint'(ones({bits1[0], cin1}) % 2));
      check("R3 carry0", longint'(cout1[0]), longint'(ones({6'd0, bits1[0][2:0]}) >= 2));
      check("R3 carry1", longint'(cout1[1]), longint'(ones({6'd0, bits1[0][5:3]}) >= 2));
      if (v < 128) k3_ref[v[6]][v[5:0]] = cout1[2];
      else check("R4 carry2 stable", longint'(cout1[2]), longint'(k3_ref[v[6]][v[5:0]]));
    end

    for (int t = 0; t < 300; t++) begin
      @(posedge clk); #1;
      for (int j = 0; j < N; j++) bits0[j] = 6'($urandom);
      cin0 = 3'($urandom);
      @(negedge clk);
      row_check("R5 random total");
    end

    @(posedge clk); #1;
    bits0 = '1; cin0 = '0;
    @(negedge clk);
    row_check("R5 all ones total");
    check("R7 carry_out all ones", longint'(cout0), 7);

    @(posedge clk); #1;
    bits0 = '1; cin0 = 3'b111;
    @(negedge clk);
    row_check("R5 saturated total");

    @(posedge clk); #1;
    bits0 = '0; cin0 = 3'b111;
    @(negedge clk);
    row_check("R7 carry_in into column 0");
    check("R7 carry_out quiet", longint'(cout0), 0);

    @(posedge clk); #1;
    bits0 = '0; bits0[N-1] = 6'b111111; cin0 = '0;
    @(negedge clk);
    row_check("R7 top column total");
    check("R7 top column carry_out", longint'(cout0), 7);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule